// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host end of a four-byte serial programming link. Once its own reset is released it runs the target's power-up procedure. It holds the target reset line and the serial clock low, then optionally gives the reset line a short high pulse while the clock stays low. It then waits a long settling interval. After that it sends the programming-enable instruction. The target shows that it is in step by echoing the instruction's second byte while the third byte is being shifted. When that echo is wrong, the host gives one extra clock pulse, which slips the target's bit framing by one position, and sends the instruction again. It makes at most 32 attempts and then reports a failure.

After a successful enable the host takes 32-bit instructions over a valid/ready request port. It shifts each instruction out most significant bit first. At the end it pulses `done` and returns the fourth byte read back from the target's data line. A request marked as a write or an erase keeps the port busy for a fixed number of cycles after completion. Every clock phase lasts `PHASE` system cycles. `PHASE` is the larger of `HALF_DIV` and the smallest count that is legal for the target's clock rate: more than 2.2 target clocks below 12 MHz, more than 3 target clocks at or above 12 MHz.

Top module: `sprog_host`

## Requirements
- R1: While `rst_n` is low, `tgt_reset`, `tgt_sck`, `req_ready`, `done`, `en_ok` and `en_fail` are all 0.
- R2: With `PULSE_RESET` set, `tgt_reset` goes high once after reset for exactly max(`RST_CYC`, 2·`SYS_PER_TGT`) cycles while `tgt_sck` stays low. It then stays low.
- R3: The first rising edge of `tgt_sck` comes no earlier than `PWR_WAIT` cycles after `tgt_reset` falls.
- R4: Every high phase of `tgt_sck` lasts exactly `PHASE` cycles and every low phase at least `PHASE` cycles. With one system cycle per target cycle and a slow target, `PHASE` is max(`HALF_DIV`, 3).
- R5: `tgt_mosi` carries each instruction most significant bit first. It changes only while `tgt_sck` is low and is unchanged across each rising edge and through each high phase.
- R6: `tgt_miso` is sampled at the end of each low phase. `done_data` holds the eight bits sampled during the fourth byte, with the first sampled bit as bit 7.
- R7: The enable instruction is 0xAC530000. It succeeds when the third received byte equals 0x53. `en_ok` then goes high and `req_ready` is raised.
- R8: On a failed enable attempt the host makes one extra `tgt_sck` pulse with `tgt_mosi` low and then resends. After 32 failed attempts `en_fail` goes high for good, `req_ready` stays low and `tgt_sck` stays low.
- R9: A request is taken when `req_valid` and `req_ready` are both high. `done` is a single-cycle pulse at the final falling edge, and `req_ready` is only high while `tgt_sck` is low.
- R10: When `req_wait` was 1, `req_ready` returns exactly `BUSY_WAIT` cycles after the `done` cycle. When it was 0, `req_ready` is already high in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction request present |
| req_ready | output | 1 | Host idle and able to take a request |
| req_cmd | input | 32 | Instruction, first byte in bits 31:24 |
| req_wait | input | 1 | Request is a write or erase; hold busy afterwards |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 8 | Fourth byte read back |
| en_ok | output | 1 | Programming enable succeeded |
| en_fail | output | 1 | All enable attempts failed |
| tgt_reset | output | 1 | Target reset line |
| tgt_sck | output | 1 | Serial clock to target |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |

## Verification
The hardest case to reach is an enable that only succeeds after many retries, or never succeeds at all. Reaching it needs a target whose bit framing is out of step with the host, and only the retry pulses can bring it back into step. The bench target starts its frame counter at a chosen offset. Each failed attempt plus its extra pulse then slips the framing by one bit, so offsets of 5 and 1 need 27 and 31 retries. The last of these succeeds on the 32nd attempt exactly. A target whose data line is stuck high forces the full failure path.

// File: rtl/sprog_host.sv
module sprog_host #(
  parameter int SYS_PER_TGT = 1,
  parameter bit TGT_FAST    = 1'b0,
  parameter int HALF_DIV    = 4,
  parameter bit PULSE_RESET = 1'b1,
  parameter int RST_CYC     = 2,
  parameter int PWR_WAIT    = 2_000_000,
  parameter int BUSY_WAIT   = 450_000,
  parameter int MAX_TRIES   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_cmd,
  input  logic        req_wait,
  output logic        done,
  output logic [7:0]  done_data,
  output logic        en_ok,
  output logic        en_fail,
  output logic        tgt_reset,
  output logic        tgt_sck,
  output logic        tgt_mosi,
  input  logic        tgt_miso
);
  localparam int MIN_PH = TGT_FAST ? 3 * SYS_PER_TGT + 1 : (22 * SYS_PER_TGT) / 10 + 1;
  localparam int PHASE  = (HALF_DIV > MIN_PH) ? HALF_DIV : MIN_PH;
  localparam int RST_W  = (RST_CYC > 2 * SYS_PER_TGT) ? RST_CYC : 2 * SYS_PER_TGT;
  localparam int TMAX0  = (PWR_WAIT > BUSY_WAIT) ? PWR_WAIT : BUSY_WAIT;
  localparam int TMAX   = (TMAX0 > RST_W) ? TMAX0 : RST_W;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int PW     = $clog2(PHASE + 1);
  localparam int NW     = $clog2(MAX_TRIES + 1);
  localparam logic [31:0] EN_CMD = 32'hAC53_0000;

  typedef enum logic [3:0] {
    S_PWR, S_RPULSE, S_WAIT, S_SHIFT, S_GAP, S_IDLE, S_BUSY, S_FAIL
  } st_t;

  st_t            st;
  logic [31:0]    tx;
  logic [15:0]    rx;
  logic [PW-1:0]  ph;
  logic [4:0]     bitn;
  logic [NW-1:0]  tries;
  logic [TW-1:0]  tmr;
  logic           is_en, waitf;

  assign tgt_mosi  = tx[31];
  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWR;
      tgt_reset <= 1'b0;
      tgt_sck   <= 1'b0;
      tx        <= '0;
      rx        <= '0;
      ph        <= '0;
      bitn      <= '0;
      tries     <= '0;
      tmr       <= '0;
      is_en     <= 1'b0;
      waitf     <= 1'b0;
      done      <= 1'b0;
      done_data <= '0;
      en_ok     <= 1'b0;
      en_fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_PWR: begin
          tmr <= '0;
          if (PULSE_RESET) begin
            tgt_reset <= 1'b1;
            st        <= S_RPULSE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_RPULSE: begin
          if (tmr == TW'(RST_W - 1)) begin
            tgt_reset <= 1'b0;
            tmr       <= '0;
            st        <= S_WAIT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_WAIT: begin
          if (tmr == TW'(PWR_WAIT - 1)) begin
            tx    <= EN_CMD;
            is_en <= 1'b1;
            bitn  <= '0;
            ph    <= '0;
            st    <= S_SHIFT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_SHIFT: begin
          if (ph == PW'(PHASE - 1)) begin
            ph <= '0;
            if (!tgt_sck) begin
              tgt_sck <= 1'b1;
              rx      <= {rx[14:0], tgt_miso};
            end else begin
              tgt_sck <= 1'b0;
              tx      <= {tx[30:0], 1'b0};
              if (bitn != 5'd31) begin
                bitn <= bitn + 1'b1;
              end else if (is_en) begin
                if (rx[15:8] == EN_CMD[23:16]) begin
                  en_ok <= 1'b1;
                  st    <= S_IDLE;
                end else if (tries == NW'(MAX_TRIES - 1)) begin
                  en_fail <= 1'b1;
                  st      <= S_FAIL;
                end else begin
                  tries <= tries + 1'b1;
                  st    <= S_GAP;
                end
              end else begin
                done      <= 1'b1;
                done_data <= rx[7:0];
                tmr       <= '0;
                st        <= (waitf && BUSY_WAIT > 0) ? S_BUSY : S_IDLE;
              end
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_GAP: begin
          if (ph == PW'(PHASE - 1)) begin
            ph <= '0;
            if (!tgt_sck) begin
              tgt_sck <= 1'b1;
            end else begin
              tgt_sck <= 1'b0;
              tx      <= EN_CMD;
              bitn    <= '0;
              st      <= S_SHIFT;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        S_IDLE: begin
          if (req_valid) begin
            tx    <= req_cmd;
            waitf <= req_wait;
            is_en <= 1'b0;
            bitn  <= '0;
            ph    <= '0;
            st    <= S_SHIFT;
          end
        end
        S_BUSY: begin
          if (tmr == TW'(BUSY_WAIT - 1)) st <= S_IDLE;
          else tmr <= tmr + 1'b1;
        end
        S_FAIL: ;
        default: st <= S_FAIL;
      endcase
    end
  end
endmodule

// File: rtl/sprog_host_chk.sv
module sprog_host_chk #(
  parameter int PH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic tgt_reset,
  input logic tgt_sck,
  input logic tgt_mosi,
  input logic req_ready,
  input logic done,
  input logic en_ok,
  input logic en_fail
);
  int   run;
  logic last_sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 0;
      last_sck <= 1'b0;
    end else begin
      last_sck <= tgt_sck;
      run      <= (tgt_sck == last_sck) ? run + 1 : 1;
    end
  end

  a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_sck) |-> run == PH);
  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_sck) |-> run >= PH);
  a_r5_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sck |-> $stable(tgt_mosi));
  a_r2_sck_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |-> !tgt_sck);
  a_r2_reset_held_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ok || en_fail) |-> !tgt_reset);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tgt_sck && en_ok));
  a_r8_fail_final: assert property (@(posedge clk) disable iff (!rst_n)
    en_fail |=> (en_fail && !req_ready && !tgt_sck));
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_ok && en_fail));
endmodule

bind sprog_host sprog_host_chk #(.PH(PHASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_reset(tgt_reset), .tgt_sck(tgt_sck),
  .tgt_mosi(tgt_mosi), .req_ready(req_ready), .done(done),
  .en_ok(en_ok), .en_fail(en_fail)
);

// File: tb/sprog_host_test.sv
`timescale 1ns/1ps
module sprog_host_test;
  localparam int PWR_WAIT  = 200;
  localparam int BUSY_WAIT = 50;
  localparam int PH_EXP    = 3;
  localparam int RST_EXP   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wait = 1'b0;
  logic [31:0] req_cmd = '0;
  logic req_ready, done, en_ok, en_fail, tgt_reset, tgt_sck, tgt_mosi;
  logic [7:0] done_data;
  logic t_miso = 1'b1;

  sprog_host #(.SYS_PER_TGT(1), .TGT_FAST(1'b0), .HALF_DIV(2), .PULSE_RESET(1'b1),
    .RST_CYC(4), .PWR_WAIT(PWR_WAIT), .BUSY_WAIT(BUSY_WAIT), .MAX_TRIES(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_wait(req_wait), .done(done), .done_data(done_data),
    .en_ok(en_ok), .en_fail(en_fail), .tgt_reset(tgt_reset), .tgt_sck(tgt_sck),
    .tgt_mosi(tgt_mosi), .tgt_miso(t_miso));

  always #5 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // behavioural target
  int t_pos = 0, t_rises = 0, t_skew = 0;
  bit t_locked = 0, t_synced = 0, t_dead = 0;
  logic [7:0]  t_r8 = '0, t_out = '0;
  logic [31:0] t_frame = '0, t_last = '0;

  always @(posedge tgt_sck) if (rst_n) begin
    t_r8    = {t_r8[6:0], tgt_mosi};
    t_frame = {t_frame[30:0], tgt_mosi};
    t_rises++;
    if (t_pos == 7) begin
      if (t_r8 == 8'hAC) t_synced = 1;
      t_locked = t_synced;
    end
    if (t_pos == 31) begin
      t_last   = t_frame;
      t_locked = 0;
    end
    t_pos = (t_pos + 1) % 32;
  end

  always @(negedge tgt_sck) if (rst_n) begin
    if (t_dead || !t_locked) t_miso = 1'b1;
    else if (t_pos >= 16 && t_pos < 24) t_miso = t_r8[7];
    else if (t_pos >= 24) begin
      if (t_pos == 24) t_out = t_r8 ^ 8'h3C;
      t_miso = t_out[7 - (t_pos - 24)];
    end else t_miso = 1'b0;
  end

  // per-clock monitor of pin-level rules
  logic p_sck = 0, p_mosi = 0, p_rst = 0, p_done = 0;
  bit seen_fall = 0, first_rise = 0;
  int run = 0, rst_hi = 0, fall_cyc = 0, ncyc = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sck = 0; p_rst = 0; p_done = 0; seen_fall = 0; first_rise = 0;
      run = 0; rst_hi = 0; fall_cyc = 0; ncyc = 0;
    end else begin
      ncyc++;
      if (tgt_sck != p_sck) begin
        if (p_sck) chk(run == PH_EXP, "R4 high phase", run, PH_EXP);
        else if (seen_fall) chk(run >= PH_EXP, "R4 low phase", run, PH_EXP);
        if (!tgt_sck) seen_fall = 1;
        run = 1;
      end else run++;
      if (tgt_sck && p_sck) chk(tgt_mosi == p_mosi, "R5 mosi stable high", tgt_mosi, p_mosi);
      if (req_ready) chk(!tgt_sck, "R9 ready with sck low", tgt_sck, 0);
      if (tgt_reset) begin
        rst_hi++;
        chk(!tgt_sck, "R2 sck low in pulse", tgt_sck, 0);
      end
      if (p_rst && !tgt_reset) begin
        chk(rst_hi == RST_EXP, "R2 pulse width", rst_hi, RST_EXP);
        fall_cyc = ncyc;
      end
      if (!first_rise && tgt_sck && !p_sck) begin
        first_rise = 1;
        chk(ncyc - fall_cyc >= PWR_WAIT, "R3 settle wait", ncyc - fall_cyc, PWR_WAIT);
      end
      if (done) chk(!p_done, "R9 single done", p_done, 0);
      p_sck = tgt_sck; p_mosi = tgt_mosi; p_rst = tgt_reset; p_done = done;
    end
  end

  task automatic power(input int skew, input bit dead);
    int n;
    rst_n = 1'b0;
    t_skew = skew; t_pos = skew; t_rises = 0; t_locked = 0; t_synced = 0;
    t_dead = dead; t_miso = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tgt_reset && !tgt_sck && !req_ready && !done && !en_ok && !en_fail,
        "R1 reset state", {tgt_reset, tgt_sck, req_ready, done, en_ok, en_fail}, 0);
    rst_n = 1'b1;
    n = 0;
    while (!en_ok && !en_fail && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic send(input logic [31:0] cmd, input bit w);
    int n;
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    req_cmd = cmd; req_wait = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk(done, "R9 done seen", done, 1);
    chk(done_data == (cmd[15:8] ^ 8'h3C), "R6 fourth byte", done_data, cmd[15:8] ^ 8'h3C);
    chk(t_last == cmd, "R5 frame received", t_last, cmd);
    n = 0;
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    chk(n == (w ? BUSY_WAIT : 0), "R10 busy hold", n, w ? BUSY_WAIT : 0);
  endtask

  initial begin
    // aligned target
    power(0, 0);
    chk(en_ok && !en_fail, "R7 enable ok", en_ok, 1);
    chk(t_rises == 32, "R7 single attempt", t_rises, 32);
    chk(req_ready, "R7 ready after enable", req_ready, 1);
    send(32'h2000_1234, 1'b0);
    send(32'hC000_5AA5, 1'b1);
    send(32'hA0FF_00C3, 1'b0);
    send(32'h4C01_FF00, 1'b1);
    // misaligned target: 27 retries
    power(5, 0);
    chk(en_ok, "R8 recovers after retries", en_ok, 1);
    chk(t_rises == 27 * 33 + 32, "R8 retry pulse count", t_rises, 27 * 33 + 32);
    send(32'h5800_8100, 1'b0);
    // needs all 32 attempts
    power(1, 0);
    chk(en_ok, "R8 last attempt ok", en_ok, 1);
    chk(t_rises == 31 * 33 + 32, "R8 last attempt count", t_rises, 31 * 33 + 32);
    send(32'h3000_7E01, 1'b1);
    // unresponsive target
    power(0, 1);
    chk(en_fail && !en_ok, "R8 give up", en_fail, 1);
    chk(t_rises == 32 * 32 + 31, "R8 attempt limit", t_rises, 32 * 32 + 31);
    req_cmd = 32'h2000_0000; req_valid = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready || tgt_sck) chk(1'b0, "R8 stays idle", {req_ready, tgt_sck}, 0);
    end
    req_valid = 1'b0;
    chk(t_rises == 32 * 32 + 31, "R8 no more clocks", t_rises, 32 * 32 + 31);
    summary();
  end
endmodule